// File: doc/BRIEF.md
# Bit-Serial Adder with Word Framing

This block adds two two's-complement numbers that arrive one bit per clock, least significant bit first. Each operand stream runs on its own wire. A framing strobe comes with the lowest bit of every word. On that bit the adder ignores the carry left over from the previous word, so words can follow each other with no gap and no counter, and each word is added on its own. The datapath is one full adder and one carry flip-flop for each lane. The `LANES` parameter sets how many independent serial adders run side by side under the same framing.

Each result bit leaves through a register one clock after its operand bits. A delayed copy of the framing strobe and of the valid flag goes with it, so a downstream deserializer can rebuild the words. When valid is low the carry and the result outputs hold their values, and the stream can stall in the middle of a word.

Top module: `sadd_top`

## Requirements
- R1: `sumOut` shows, one clock after a cycle with `inValid` high, the XOR of that cycle's `opA`, `opB` and the carry-in for the bit.
- R2: Between bits of the same word, the carry-in for a bit is the majority of the previous bit's `opA`, `opB` and carry-in. So 1+1 in one bit makes the next bit of 0+0 come out as 1.
- R3: On a valid cycle with `inFirst` high, the carry-in is 0 whatever carry the previous word left behind.
- R4: On a cycle with `inValid` low, the stored carry does not change, and `sumOut` and `firstOut` keep their values on the next clock.
- R5: `validOut` equals `inValid` delayed by one clock. After a valid cycle, `firstOut` equals that cycle's `inFirst`.
- R6: A synchronous active-high `rst` clears the carry to 0 and drives `validOut`, `firstOut` and `sumOut` to 0 on the next clock.
- R7: Words streamed back to back, with no idle cycles and `inFirst` high on bit 0, come out as (a + b) mod 2^W for each word, with overflow wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand bits on this cycle are valid |
| inFirst | input | 1 | This cycle carries bit 0 of a word |
| opA | input | LANES | Serial bit of operand A, one per lane |
| opB | input | LANES | Serial bit of operand B, one per lane |
| validOut | output | 1 | Registered copy of inValid |
| firstOut | output | 1 | Registered framing bit of the current result bit |
| sumOut | output | LANES | Registered sum bit, one per lane |

## Verification
The bench goes after a leftover carry at a word boundary. A 0xFF+0x01 word is followed at once by a 0+0 word. A design that did not clear the carry on the framing bit would return 1 for the second word instead of 0. A stall in the middle of a word checks that the carry is frozen. A design that let the carry update or decay while valid was low would corrupt the upper bits of that word, and it would also change the held result bit. Reset is checked after a word that leaves a carry of 1. Sending an unframed 0+0 bit after reset would give 1 if the reset did not clear the carry. Random back-to-back words check that overflow wraps.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef struct packed {
    logic advance;
    logic clearCarry;
  } saddStrobe_t;
endpackage

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inFirst,
  output saddStrobe_t strobe,
  output logic        validOut,
  output logic        firstOut
);
  always_comb begin
    strobe.advance    = inValid;
    strobe.clearCarry = inValid & inFirst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      firstOut <= 1'b0;
    end else begin
      validOut <= inValid;
      if (inValid) firstOut <= inFirst;
    end
  end
endmodule

// File: rtl/sadd_dp.sv
module sadd_dp
  import sadd_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  saddStrobe_t       strobe,
  input  logic [LANES-1:0]  opA,
  input  logic [LANES-1:0]  opB,
  output logic [LANES-1:0]  sumOut
);
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic carryQ;
    logic carryIn;
    logic sumBit;
    logic carryNext;

    always_comb begin
      carryIn   = strobe.clearCarry ? 1'b0 : carryQ;
      sumBit    = opA[ln] ^ opB[ln] ^ carryIn;
      carryNext = (opA[ln] & opB[ln]) | (opA[ln] & carryIn) | (opB[ln] & carryIn);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        carryQ     <= 1'b0;
        sumOut[ln] <= 1'b0;
      end else if (strobe.advance) begin
        carryQ     <= carryNext;
        sumOut[ln] <= sumBit;
      end
    end
  end
endmodule

// File: rtl/sadd_top.sv
module sadd_top
  import sadd_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inFirst,
  input  logic [LANES-1:0] opA,
  input  logic [LANES-1:0] opB,
  output logic             validOut,
  output logic             firstOut,
  output logic [LANES-1:0] sumOut
);
  saddStrobe_t strobe;

  sadd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .strobe   (strobe),
    .validOut (validOut),
    .firstOut (firstOut)
  );

  sadd_dp #(.LANES(LANES)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .sumOut (sumOut)
  );
endmodule

// File: rtl/sadd_checker.sv
module sadd_checker #(
  parameter int LANES = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inFirst,
  input logic [LANES-1:0] opA,
  input logic [LANES-1:0] opB,
  input logic             validOut,
  input logic             firstOut,
  input logic [LANES-1:0] sumOut
);
  // R3: a framing bit adds with zero carry-in
  p_first_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inFirst) |=> (sumOut == ($past(opA) ^ $past(opB))));

  // R2: a generate in one bit carries into the next 0+0 bit of the same word
  p_carry_chain_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && opA[0] && opB[0]) ##1 (inValid && !inFirst && !opA[0] && !opB[0])
      |=> sumOut[0]);

  // R4: results hold while the input is idle
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(sumOut) && $stable(firstOut)));

  // R5: valid and framing travel one clock behind the operands
  p_valid_delay_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (validOut == $past(inValid)));
  p_first_delay_r5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (firstOut == $past(inFirst)));

  // R6: reset clears the outputs
  p_reset_out_r6: assert property (@(posedge clk)
    rst |=> (!validOut && !firstOut && (sumOut == '0)));
endmodule

bind sadd_top sadd_checker #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inFirst  (inFirst),
  .opA      (opA),
  .opB      (opB),
  .validOut (validOut),
  .firstOut (firstOut),
  .sumOut   (sumOut)
);

// File: tb/sadd_top_bench.sv
`timescale 1ns/1ps
module sadd_top_bench;
  localparam int W = 8;
  localparam int MAXW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inFirst = 1'b0;
  logic [0:0] opA = '0;
  logic [0:0] opB = '0;
  logic validOut, firstOut;
  logic [0:0] sumOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // sampled outputs, taken at each negedge before new inputs are driven
  logic sV, sF, sS;
  logic [W-1:0] rxWord [MAXW];
  int rxIdx;
  int rxPos;

  always #10 clk = ~clk;

  sadd_top u_sadd_top (
    .clk(clk), .rst(rst), .inValid(inValid), .inFirst(inFirst),
    .opA(opA), .opB(opB), .validOut(validOut), .firstOut(firstOut), .sumOut(sumOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic f, input logic a, input logic b);
    @(negedge clk);
    sV = validOut; sF = firstOut; sS = sumOut[0];
    if (sV) begin
      if (sF) begin rxIdx++; rxPos = 0; end
      if (rxIdx >= 0 && rxIdx < MAXW && rxPos < W) rxWord[rxIdx][rxPos] = sS;
      rxPos++;
    end
    inValid = v; inFirst = f; opA[0] = a; opB[0] = b;
  endtask

  task automatic rxClear();
    rxIdx = -1; rxPos = 0;
  endtask

  // R6: reset state and carry cleared by reset
  task automatic testReset();
    rxClear();
    for (int i = 0; i < W; i++) cycle(1'b1, i == 0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    check("R6 validOut", validOut, 0);
    check("R6 firstOut", firstOut, 0);
    check("R6 sumOut", sumOut, 0);
    rst = 1'b0;
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 carry cleared", sS, 0);
    check("R5 validOut after bit", sV, 1);
  endtask

  // R3: leftover carry must not leak into the next word
  task automatic testFirstClears();
    logic [W-1:0] a [2];
    logic [W-1:0] b [2];
    a[0] = 8'hFF; b[0] = 8'h01; a[1] = 8'h00; b[1] = 8'h00;
    rxClear();
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < W; i++) cycle(1'b1, i == 0, a[w][i], b[w][i]);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 word FF+01", rxWord[0], 8'h00);
    check("R3 word after carry", rxWord[1], 8'h00);
    check("R5 word count", rxIdx, 1);
  endtask

  // R2 and R1: carry ripples through a word
  task automatic testCarryChain();
    rxClear();
    for (int i = 0; i < W; i++) cycle(1'b1, i == 0, (8'h7F >> i) & 1, (8'h01 >> i) & 1);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 ripple 7F+01", rxWord[0], 8'h80);
    rxClear();
    for (int i = 0; i < W; i++) cycle(1'b1, i == 0, (8'h55 >> i) & 1, (8'h22 >> i) & 1);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 no-carry 55+22", rxWord[0], 8'h77);
  endtask

  // R4: stall mid-word
  task automatic testStall();
    logic [W-1:0] a = 8'h6B;
    logic [W-1:0] b = 8'h3D;
    logic held;
    rxClear();
    for (int i = 0; i < W; i++) begin
      cycle(1'b1, i == 0, a[i], b[i]);
      if (i == 3) begin
        cycle(1'b0, 1'b0, 1'b1, 1'b1);
        held = sS;
        cycle(1'b0, 1'b1, 1'b1, 1'b0);
        check("R4 idle validOut", sV, 0);
        check("R4 sum held", sS, held);
        check("R4 first held", sF, 0);
      end
    end
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 word across stall", rxWord[0], a + b);
  endtask

  // R7 and R5: random back-to-back words
  task automatic testBackToBack();
    logic [W-1:0] a [MAXW];
    logic [W-1:0] b [MAXW];
    for (int w = 0; w < MAXW; w++) begin
      a[w] = W'($urandom); b[w] = W'($urandom);
    end
    a[0] = 8'h80; b[0] = 8'h80;
    rxClear();
    for (int w = 0; w < MAXW; w++)
      for (int i = 0; i < W; i++) cycle(1'b1, i == 0, a[w][i], b[w][i]);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 frames seen", rxIdx, MAXW - 1);
    for (int w = 0; w < MAXW; w++) begin
      logic [W-1:0] exp;
      exp = a[w] + b[w];
      check("R7 back-to-back word", rxWord[w], exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFirstClears();
    testCarryChain();
    testStall();
    testBackToBack();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule